// File: doc/BRIEF.md
# Periodic Battery Load-Test Scheduler

This block decides when a backup battery is put under load for a health check, and it drives the two active-low battery warning indicators. All of its timing comes from a free-running 2 Hz strobe (`half_tick`, high for one system clock every 0.5 s). Two half ticks make one second. A day counter counts half ticks, and once per day it starts a load-test pulse that lasts exactly one second. A bus command byte of 1Ah, already decoded upstream, asks for an extra test. The request is held until the next half tick so that every pulse starts on the 2 Hz grid and lasts a full second.

When a pulse ends, the block samples the analog comparator verdict (`cmp_low`) into the low-battery flag. A small control register does three things. It selects either the on-chip divider and load or an external resistor network. It sets the low-battery warning to steady or blinking. It sets the on-battery warning to steady or blinking. A blinking warning follows a shared phase bit that toggles on every half tick, so every blinking output stays in step.

The default `DAY_SECS` of 86400 gives the 24-hour period. A smaller value shortens the schedule for test.

Top module: `batt_test_sched`

## Requirements
- R1: `test_o` rises in the cycle after the half tick that ends each day, which is every 2*DAY_SECS half ticks after reset. It stays high for exactly two half-tick periods and is 0 at all other times.
- R2: A `cmd_valid` cycle with `cmd_code` = 8'h1A while `test_o` is 0 queues a test. The test then starts at the next half tick, exactly as a scheduled one. Several such commands before that tick still give only one pulse.
- R3: A 1Ah command that arrives while `test_o` is 1 is dropped. It neither lengthens the running pulse nor causes a later one. A command with any other code has no effect.
- R4: `batt_low` resets to 0. It is loaded from `cmp_low` only at the half tick that ends a pulse, becomes visible in the cycle after that tick, and holds its value at all other times.
- R5: The control register resets to 8'h00. A `ctl_wr` cycle stores bits 0, 1 and 5 of `ctl_wdata`. All other bits read back as 0. `ctl_rdata` shows the new value from the next cycle.
- R6: With control bit 5 = 0, `int_div_en` is 1 and `int_load_en` equals `test_o`. With bit 5 = 1, both are 0 and only `test_o` drives the external network.
- R7: An inactive warning drives its output (`batt_on_n`, `batt_lo_n`) high. The on-battery warning is active while `on_batt` is 1. The low-battery warning is active while `batt_low` is 1.
- R8: An active warning whose blink bit is 0 drives its output steadily low. Control bit 0 is the blink bit for `batt_on_n`, and control bit 1 is the blink bit for `batt_lo_n`.
- R9: An active warning whose blink bit is 1 drives its output equal to the blink phase. The phase is 0 after reset and toggles at every half tick, so the output is low for 0.5 s and high for 0.5 s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_tick | input | 1 | One-cycle strobe every 0.5 s |
| cmd_valid | input | 1 | Decoded bus command strobe |
| cmd_code | input | 8 | Command byte, 8'h1A forces a test |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| on_batt | input | 1 | System is running from the battery |
| cmp_low | input | 1 | Comparator verdict: battery below trip point |
| ctl_rdata | output | 8 | Control register contents |
| test_o | output | 1 | Load-test pulse |
| int_load_en | output | 1 | Connect internal load during test |
| int_div_en | output | 1 | Internal divider selected |
| batt_low | output | 1 | Low-battery flag |
| batt_on_n | output | 1 | On-battery warning, active low |
| batt_lo_n | output | 1 | Low-battery warning, active low |

## Verification
`test_o`, `batt_low` and the blink phase each pass through one register clocked on the half-tick cycle, so their new values show one clock after the strobe. `ctl_rdata` follows a write by one clock. The warning outputs, `int_div_en` and `int_load_en` follow those registers and `on_batt` with no added delay. The bench drives every strobe on a falling edge and releases it one clock later. It then waits two more falling edges before it compares all outputs against its own half-tick-stepped model, so every result it samples has already settled.

// File: rtl/bts_pkg.sv
// Shared constants and types for the battery load-test scheduler.
// Assumes: one command byte value requests a test; control fields sit at
// fixed bit positions that software writes.
package bts_pkg;
    localparam logic [7:0] CMD_FORCE_TEST = 8'h1A;
    localparam int         BIT_ON_BLINK   = 0;
    localparam int         BIT_LO_BLINK   = 1;
    localparam int         BIT_EXT_SEL    = 5;
    localparam logic [7:0] CTL_MASK       = 8'h23;

    typedef struct packed {
        logic ext_sel;
        logic lo_blink;
        logic on_blink;
    } ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } tst_state_e;
endpackage

// File: rtl/bts_timebase.sv
// Time base: keeps the shared blink phase and counts half ticks through one day.
// Assumes half_tick is a single-cycle strobe every 0.5 s.
module bts_timebase #(
    parameter int HALF_PER_DAY = 172800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    output logic blink_ph,
    output logic day_due
);
    localparam int CW = (HALF_PER_DAY > 1) ? $clog2(HALF_PER_DAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PER_DAY - 1);

    logic [CW-1:0] cnt_q;
    logic          ph_q;

    // Advance the day position and the blink phase on every half tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (half_tick) begin
            ph_q  <= ~ph_q;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // A day ends on the half tick that wraps the counter.
    always_comb begin
        day_due  = half_tick && (cnt_q == LAST);
        blink_ph = ph_q;
    end
endmodule

// File: rtl/bts_ctl_reg.sv
// Control register: two blink enables and the external network select.
// Assumes a single-cycle write strobe; unused bits are not stored.
module bts_ctl_reg
    import bts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output logic [7:0] rdata
);
    ctl_t ctl_q;
    logic unused_bits;

    // Capture the three defined fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q.on_blink <= wdata[BIT_ON_BLINK];
            ctl_q.lo_blink <= wdata[BIT_LO_BLINK];
            ctl_q.ext_sel  <= wdata[BIT_EXT_SEL];
        end
    end

    // Place the fields back at their bit positions for readback.
    always_comb begin
        rdata               = 8'h00;
        rdata[BIT_ON_BLINK] = ctl_q.on_blink;
        rdata[BIT_LO_BLINK] = ctl_q.lo_blink;
        rdata[BIT_EXT_SEL]  = ctl_q.ext_sel;
        ctl                 = ctl_q;
    end

    assign unused_bits = ^{wdata[7:6], wdata[4:2]};
endmodule

// File: rtl/bts_pulse.sv
// Test pulse sequencer: starts a one-second pulse on a day boundary or on a
// queued force command, and samples the comparator as the pulse ends.
// Assumes every pulse starts and ends on a half tick.
module bts_pulse
    import bts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic       day_due,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       cmp_low,
    output logic       test,
    output logic       low_flag
);
    tst_state_e st_q;
    logic       pend_q;
    logic       low_q;
    logic       cmd_hit;

    // Decode the force command.
    always_comb cmd_hit = cmd_valid && (cmd_code == CMD_FORCE_TEST);

    // Sequence the pulse over two half ticks and keep the force request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
            low_q  <= 1'b0;
        end else begin
            if (cmd_hit && (st_q == ST_IDLE) && !half_tick) begin
                pend_q <= 1'b1;
            end
            if (half_tick) begin
                case (st_q)
                    ST_IDLE: begin
                        if (day_due || pend_q || cmd_hit) begin
                            st_q   <= ST_FIRST;
                            pend_q <= 1'b0;
                        end
                    end
                    ST_FIRST:  st_q <= ST_SECOND;
                    ST_SECOND: begin
                        st_q  <= ST_IDLE;
                        low_q <= cmp_low;
                    end
                    default:   st_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Expose the pulse and the low-battery flag.
    always_comb begin
        test     = (st_q != ST_IDLE);
        low_flag = low_q;
    end
endmodule

// File: rtl/bts_warn.sv
// Warning drivers: each active-low output is high when idle, low when active
// and steady, or follows the shared blink phase when active and blinking.
// Assumes blink_ph is common to all channels so that they blink together.
module bts_warn #(
    parameter int N = 2
) (
    input  logic [N-1:0] active,
    input  logic [N-1:0] blink_en,
    input  logic         blink_ph,
    output logic [N-1:0] out_n
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        // Choose idle-high, steady-low or phase for one channel.
        always_comb begin
            if (!active[i])       out_n[i] = 1'b1;
            else if (blink_en[i]) out_n[i] = blink_ph;
            else                  out_n[i] = 1'b0;
        end
    end
endmodule

// File: rtl/batt_test_sched.sv
// Top of the battery load-test scheduler: day timing, force command,
// network select, low-battery flag and warning drivers.
// Assumes half_tick arrives every 0.5 s; DAY_SECS sets the test interval.
module batt_test_sched
    import bts_pkg::*;
#(
    parameter int DAY_SECS = 86400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       on_batt,
    input  logic       cmp_low,
    output logic [7:0] ctl_rdata,
    output logic       test_o,
    output logic       int_load_en,
    output logic       int_div_en,
    output logic       batt_low,
    output logic       batt_on_n,
    output logic       batt_lo_n
);
    localparam int HALF_PER_DAY = 2 * DAY_SECS;

    ctl_t       ctl;
    logic       blink_ph;
    logic       day_due;
    logic [1:0] warn_n;

    bts_timebase #(.HALF_PER_DAY(HALF_PER_DAY)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_tick(half_tick),
        .blink_ph (blink_ph),
        .day_due  (day_due)
    );

    bts_ctl_reg u_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (ctl_wr),
        .wdata(ctl_wdata),
        .ctl  (ctl),
        .rdata(ctl_rdata)
    );

    bts_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_tick(half_tick),
        .day_due  (day_due),
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .cmp_low  (cmp_low),
        .test     (test_o),
        .low_flag (batt_low)
    );

    bts_warn #(.N(2)) u_warn (
        .active  ({batt_low, on_batt}),
        .blink_en({ctl.lo_blink, ctl.on_blink}),
        .blink_ph(blink_ph),
        .out_n   (warn_n)
    );

    // Route the network select and the warning outputs.
    always_comb begin
        int_div_en  = ~ctl.ext_sel;
        int_load_en = test_o & ~ctl.ext_sel;
        batt_on_n   = warn_n[0];
        batt_lo_n   = warn_n[1];
    end
endmodule

// File: rtl/batt_test_sched_chk.sv
// Checker for batt_test_sched: pulse framing, flag timing, network select
// and warning levels. Bound to every instance of the top module.
module batt_test_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       half_tick,
    input logic       on_batt,
    input logic [7:0] ctl_rdata,
    input logic       test_o,
    input logic       int_load_en,
    input logic       int_div_en,
    input logic       batt_low,
    input logic       batt_on_n,
    input logic       batt_lo_n
);
    logic [1:0] seen_q;

    // Count the half ticks seen while a pulse is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_o) seen_q <= 2'd0;
        else if (half_tick)    seen_q <= seen_q + 2'd1;
    end

    a_r1_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_o) |-> $past(half_tick));
    a_r1_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_o) |-> ($past(half_tick) && $past(seen_q) == 2'd1));
    a_r3_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        test_o |-> (seen_q <= 2'd1));
    a_r4_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(batt_low) |-> $fell(test_o));
    a_r6_load_in_test: assert property (@(posedge clk) disable iff (!rst_n)
        int_load_en |-> (test_o && int_div_en));
    a_r6_ext_no_div: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[5] |-> (!int_div_en && !int_load_en));
    a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_batt |-> batt_on_n) and (!batt_low |-> batt_lo_n));
    a_r8_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
        (on_batt && !ctl_rdata[0]) |-> !batt_on_n);
    a_r9_blink_together: assert property (@(posedge clk) disable iff (!rst_n)
        (on_batt && batt_low && ctl_rdata[0] && ctl_rdata[1]) |-> (batt_on_n == batt_lo_n));
endmodule

bind batt_test_sched batt_test_sched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .on_batt    (on_batt),
    .ctl_rdata  (ctl_rdata),
    .test_o     (test_o),
    .int_load_en(int_load_en),
    .int_div_en (int_div_en),
    .batt_low   (batt_low),
    .batt_on_n  (batt_on_n),
    .batt_lo_n  (batt_lo_n)
);

// File: tb/tb_batt_test_sched.sv
// Bench: sweeps control settings, supply state and comparator level over a
// short day, and compares every output after each half tick with a model.
module tb_batt_test_sched;
    localparam int DAY  = 4;
    localparam int HPD  = 2 * DAY;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       on_batt = 1'b0;
    logic       cmp_low = 1'b0;
    logic [7:0] ctl_rdata;
    logic       test_o, int_load_en, int_div_en, batt_low, batt_on_n, batt_lo_n;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // Model state
    int   m_day = 0;
    bit   m_ph = 0, m_test = 0, m_h = 0, m_pend = 0, m_low = 0;
    logic [7:0] m_ctl = 8'h00;

    always #10 clk = ~clk;

    batt_test_sched #(.DAY_SECS(DAY)) dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit warn_exp(input bit act, input bit blink);
        if (!act) return 1'b1;
        return blink ? m_ph : 1'b0;
    endfunction

    task automatic check_all();
        chk("R1 test_o", {7'd0, test_o}, {7'd0, m_test});
        chk("R4 batt_low", {7'd0, batt_low}, {7'd0, m_low});
        chk("R6 int_div_en", {7'd0, int_div_en}, {7'd0, ~m_ctl[5]});
        chk("R6 int_load_en", {7'd0, int_load_en}, {7'd0, m_test & ~m_ctl[5]});
        chk("R7/R8/R9 batt_on_n", {7'd0, batt_on_n}, {7'd0, warn_exp(on_batt, m_ctl[0])});
        chk("R7/R8/R9 batt_lo_n", {7'd0, batt_lo_n}, {7'd0, warn_exp(m_low, m_ctl[1])});
    endtask

    task automatic tick();
        bit due;
        @(negedge clk) half_tick = 1'b1;
        due   = (m_day == HPD - 1);
        m_day = (m_day + 1) % HPD;
        m_ph  = ~m_ph;
        if (m_test) begin
            if (m_h) begin m_test = 0; m_low = cmp_low; end
            else m_h = 1;
        end else if (due || m_pend) begin
            m_test = 1; m_h = 0; m_pend = 0;
        end
        @(negedge clk) half_tick = 1'b0;
        repeat (2) @(negedge clk);
        check_all();
    endtask

    task automatic send_cmd(input logic [7:0] code);
        @(negedge clk) begin cmd_valid = 1'b1; cmd_code = code; end
        if (!m_test && code == 8'h1A) m_pend = 1;
        @(negedge clk) cmd_valid = 1'b0;
    endtask

    task automatic write_ctl(input logic [7:0] d);
        @(negedge clk) begin ctl_wr = 1'b1; ctl_wdata = d; end
        m_ctl = d & 8'h23;
        @(negedge clk) ctl_wr = 1'b0;
        chk("R5 ctl_rdata", ctl_rdata, m_ctl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R5, R4, R7)
        chk("R5 reset ctl", ctl_rdata, 8'h00);
        check_all();

        // R5: undefined bits read as zero
        write_ctl(8'hFF);
        write_ctl(8'h00);

        // R1: untouched schedule over two days
        for (int i = 0; i < 2 * HPD; i++) tick();

        // R2: two force commands before a tick give one pulse
        send_cmd(8'h1A);
        send_cmd(8'h1A);
        for (int i = 0; i < 4; i++) tick();

        // R3: force during a running pulse, and a wrong code while idle
        while (!m_test) tick();
        send_cmd(8'h1A);
        for (int i = 0; i < 4; i++) tick();
        send_cmd(8'h1B);
        for (int i = 0; i < 3; i++) tick();

        // Sweep: control fields x supply state x comparator level
        for (int cfg = 0; cfg < 8; cfg++) begin
            write_ctl({2'b00, cfg[2], 3'b000, cfg[1], cfg[0]} | 8'hDC);
            for (int ob = 0; ob < 2; ob++) begin
                for (int cl = 0; cl < 2; cl++) begin
                    @(negedge clk) begin on_batt = ob[0]; cmp_low = cl[0]; end
                    @(negedge clk);
                    check_all();
                    send_cmd((cfg % 2 == 0) ? 8'h1A : 8'h1B);
                    for (int k = 0; k < 6; k++) tick();
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule